// File: doc/BRIEF.md
# Polled Console Port

This block sits between a CPU bus and a character terminal. The CPU reaches it through two 8-bit port addresses: a status port it polls, and a data port it reads for received keys and writes for characters to display. Reads are combinational. The read data is valid in the same cycle as the read strobe. A read of the data port takes effect on the clock edge that ends the strobe.

Key bytes arrive on a valid/ready stream. `key_ready` is high only while the one-byte holding register is empty. A beat whose `key_valid` is high while `key_ready` is low is not taken. The source may hold it or drop it, and the block never stores it.

Taking a byte raises `irq`. The request stays up until the CPU reads the data port or pulses `irq_ack`.

Transmit characters leave as a single-cycle `tx_valid` strobe, one cycle after the data-port write. The transmit path has no back-pressure. The sink must accept every beat, and the status port always reports it ready.

Top module: `con_port`

## Requirements
- R1: After reset `irq` and `tx_valid` are low, `key_ready` is high, and `bus_rdata_oe` is low while no read is strobed.
- R2: A read of address 0x80 returns 0x02 when no byte is held and 0x03 when one is held. Bit 1 is always 1 (ready to send), bit 0 is the pending flag, and bits 7..2 are 0.
- R3: A read of address 0x81 while a byte is held returns that byte and empties the register. After that read the status reads 0x02.
- R4: A read of address 0x81 while nothing is held returns 0x13.
- R5: A key beat offered while a byte is held is not taken, and `key_ready` is low during it. The held byte stays unchanged, and the next empty read returns 0x13.
- R6: A key beat taken on a clock edge makes `irq` high and `key_ready` low from that edge on.
- R7: `irq` stays high until a data-port read or an `irq_ack` pulse. An acknowledge clears `irq` but leaves the byte held.
- R8: A write to address 0x81 makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written byte.
- R9: A write to address 0x80 raises no `tx_valid` and changes neither the held byte nor `irq`.
- R10: Reads and writes to any other address leave `bus_rdata_oe` low and `bus_rdata` at 0x00. They raise no `tx_valid` and do not empty the register.
- R11: The Return key code 0x0D passes through the holding register unchanged, like any other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | CPU port address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 unless a mapped port is read |
| bus_rdata_oe | output | 1 | High while this block drives read data |
| key_valid | input | 1 | Key byte offered |
| key_data | input | 8 | Key byte |
| key_ready | output | 1 | Holding register empty; a beat is taken when valid and ready are both high |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request, a received byte is pending |
| tx_valid | output | 1 | One-cycle strobe of a character to display |
| tx_data | output | 8 | Character to display |

## Verification
The only state is the holding register with its full flag, the interrupt flag and the transmit register. A wrong full flag shows in the same cycle, either as a wrong bit 0 on a status read or as `key_ready` at the wrong level. A lost or overwritten held byte shows only at the next data-port read, so every test that offers a second key ends by draining the register and checking both the first byte and the 0x13 that follows. An `irq` that clears at the wrong time is seen one cycle after the offending read, acknowledge or key beat.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] STATUS_PORT = 8'h80;
  localparam logic [BYTE_W-1:0] DATA_PORT   = 8'h81;
  localparam logic [BYTE_W-1:0] IDLE_CODE   = 8'h13;
  localparam int unsigned TX_RDY_BIT  = 1;
  localparam int unsigned PENDING_BIT = 0;

  typedef struct packed {
    logic stat_rd;
    logic stat_wr;
    logic data_rd;
    logic data_wr;
  } con_sel_t;
endpackage

// File: rtl/con_decode.sv
module con_decode
  import con_pkg::*;
#(
  parameter int unsigned ADDR_W = BYTE_W,
  parameter logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_PORT),
  parameter logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output con_sel_t          sel
);
  logic hit_stat, hit_data;

  always_comb begin
    hit_stat    = (addr == STAT_A);
    hit_data    = (addr == DATA_A);
    sel.stat_rd = rd && hit_stat;
    sel.stat_wr = wr && hit_stat;
    sel.data_rd = rd && hit_data;
    sel.data_wr = wr && hit_data;
  end
endmodule

// File: rtl/con_rxbuf.sv
module con_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_data,
  output logic              key_ready,
  input  logic              pop,
  input  logic              ack,
  output logic              full,
  output logic [DATA_W-1:0] held,
  output logic              irq
);
  logic take;

  assign key_ready = !full;
  assign take      = key_valid && key_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
      irq  <= 1'b0;
    end else if (take) begin
      full <= 1'b1;
      held <= key_data;
      irq  <= 1'b1;
    end else if (pop) begin
      full <= 1'b0;
      irq  <= 1'b0;
    end else if (ack) begin
      irq  <= 1'b0;
    end
  end

  // R7: a request never stands without a pending byte
  p_irq_has_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> full);

  // R6: a taken beat is held and signalled on the next cycle
  p_take_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready) |=> (irq && full && held == $past(key_data)));

  // R5: a beat offered while full leaves the held byte alone
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(held)));

  // R3: reading the data port empties the register
  p_pop_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop) |=> !full);
endmodule

// File: rtl/con_rdmux.sv
module con_rdmux
  import con_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter logic [DATA_W-1:0] EMPTY_CODE = DATA_W'(IDLE_CODE),
  parameter int unsigned RDY_BIT = TX_RDY_BIT,
  parameter int unsigned PEND_BIT = PENDING_BIT
) (
  input  con_sel_t          sel,
  input  logic              full,
  input  logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word           = '0;
    status_word[RDY_BIT]  = 1'b1;
    status_word[PEND_BIT] = full;
  end

  always_comb begin
    oe    = sel.stat_rd || sel.data_rd;
    rdata = '0;
    if (sel.stat_rd)      rdata = status_word;
    else if (sel.data_rd) rdata = full ? held : EMPTY_CODE;
  end
endmodule

// File: rtl/con_port.sv
module con_port
  import con_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned ADDR_W = BYTE_W,
  parameter logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_PORT),
  parameter logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_data,
  output logic              key_ready,
  input  logic              irq_ack,
  output logic              irq,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  con_sel_t          sel;
  logic              full;
  logic [DATA_W-1:0] held;

  con_decode #(.ADDR_W(ADDR_W), .STAT_A(STAT_A), .DATA_A(DATA_A)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .sel(sel)
  );

  con_rxbuf #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
    .pop(sel.data_rd), .ack(irq_ack),
    .full(full), .held(held), .irq(irq)
  );

  con_rdmux #(.DATA_W(DATA_W)) u_mux (
    .sel(sel), .full(full), .held(held), .rdata(bus_rdata), .oe(bus_rdata_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= sel.data_wr;
      if (sel.data_wr) tx_data <= bus_wdata;
    end
  end

  // R10: at most one port selected, and no drive off the map
  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.stat_rd, sel.data_rd}));
  p_quiet_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != STAT_A && bus_addr != DATA_A) |-> (!bus_rdata_oe && bus_rdata == '0));

  // R8: each transmit beat follows a data-port write and lasts one cycle
  p_tx_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(bus_wr) && $past(bus_addr) == DATA_A && tx_data == $past(bus_wdata)));

  // R9: a status write leaves request and transmit untouched
  p_stat_wr_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STAT_A && !bus_rd && !key_valid && !irq_ack) |=> (!tx_valid && $stable(irq)));

  // R2: a status read always reports ready to send
  p_ready_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == STAT_A) |-> (bus_rdata[TX_RDY_BIT] && bus_rdata[DATA_W-1:2] == '0));
endmodule

// File: tb/test_con_port.sv
module test_con_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe;
  logic       key_valid = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       key_ready;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       tx_valid;
  logic [7:0] tx_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  con_port i_con_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
    .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
    .irq_ack(irq_ack), .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_port(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata; oe = bus_rdata_oe;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_port(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_key(input logic [7:0] v);
    @(negedge clk);
    key_valid = 1'b1; key_data = v;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    check(key_ready == 1'b1, "R1 key_ready", key_ready, 1);
    check(bus_rdata_oe == 1'b0, "R1 oe", bus_rdata_oe, 0);
  endtask

  task automatic t_empty_reads;
    logic [7:0] d; logic oe;
    rd_port(8'h80, d, oe);
    check(d == 8'h02 && oe, "R2 status empty", d, 8'h02);
    rd_port(8'h81, d, oe);
    check(d == 8'h13 && oe, "R4 empty data", d, 8'h13);
  endtask

  task automatic t_receive_and_drop;
    logic [7:0] d; logic oe;
    send_key(8'h41);
    check(irq == 1'b1, "R6 irq", irq, 1);
    check(key_ready == 1'b0, "R6 key_ready", key_ready, 0);
    rd_port(8'h80, d, oe);
    check(d == 8'h03, "R2 status pending", d, 8'h03);
    @(negedge clk);
    key_valid = 1'b1; key_data = 8'h42;
    #1;
    check(key_ready == 1'b0, "R5 ready while full", key_ready, 0);
    @(negedge clk);
    key_valid = 1'b0;
    rd_port(8'h81, d, oe);
    check(d == 8'h41, "R5 held byte kept", d, 8'h41);
    check(irq == 1'b0, "R7 irq cleared by read", irq, 0);
    rd_port(8'h80, d, oe);
    check(d == 8'h02, "R3 emptied", d, 8'h02);
    rd_port(8'h81, d, oe);
    check(d == 8'h13, "R5 dropped beat absent", d, 8'h13);
  endtask

  task automatic t_return_key;
    logic [7:0] d; logic oe;
    send_key(8'h0D);
    rd_port(8'h81, d, oe);
    check(d == 8'h0D, "R11 return code", d, 8'h0D);
  endtask

  task automatic t_ack;
    logic [7:0] d; logic oe;
    send_key(8'h55);
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R7 irq held", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b0, "R7 irq acked", irq, 0);
    rd_port(8'h80, d, oe);
    check(d == 8'h03, "R7 byte kept after ack", d, 8'h03);
    rd_port(8'h81, d, oe);
    check(d == 8'h55, "R3 byte after ack", d, 8'h55);
  endtask

  task automatic t_transmit;
    @(negedge clk);
    bus_addr = 8'h81; bus_wdata = 8'h5A; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(tx_valid == 1'b1, "R8 tx_valid", tx_valid, 1);
    check(tx_data == 8'h5A, "R8 tx_data", tx_data, 8'h5A);
    @(negedge clk);
    check(tx_valid == 1'b0, "R8 one cycle", tx_valid, 0);
  endtask

  task automatic t_status_write;
    logic [7:0] d; logic oe;
    send_key(8'h27);
    @(negedge clk);
    bus_addr = 8'h80; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(tx_valid == 1'b0, "R9 no tx", tx_valid, 0);
    check(irq == 1'b1, "R9 irq kept", irq, 1);
    rd_port(8'h81, d, oe);
    check(d == 8'h27, "R9 byte kept", d, 8'h27);
  endtask

  task automatic t_unmapped;
    logic [7:0] d; logic oe;
    send_key(8'h64);
    rd_port(8'h82, d, oe);
    check(!oe && d == 8'h00, "R10 no drive 0x82", {oe, d}, 0);
    rd_port(8'h7F, d, oe);
    check(!oe && d == 8'h00, "R10 no drive 0x7F", {oe, d}, 0);
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 8'hAA; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(tx_valid == 1'b0, "R10 no tx", tx_valid, 0);
    rd_port(8'h80, d, oe);
    check(d == 8'h03, "R10 byte still held", d, 8'h03);
    rd_port(8'h81, d, oe);
    check(d == 8'h64, "R10 held value", d, 8'h64);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_empty_reads;
    t_receive_and_drop;
    t_return_key;
    t_ack;
    t_transmit;
    t_status_write;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule